// File: doc/BRIEF.md
# ADC Conversion Trigger Controller

This block decides when a successive-approximation converter starts a conversion and reports whether one is running. A small bus-side register interface holds two registers: a channel register that carries a 5-bit input-select code, and a status/control register that carries the busy flag, the trigger-source bit and two stored compare-mode bits. The converter core is outside the block. It receives a one-cycle start pulse, the latched channel code and an abort pulse. It returns a one-cycle conversion-done pulse.

A conversion starts in one of two ways, chosen by the trigger-source bit. With the bit at 0, every write of a usable code to the channel register starts a conversion. With the bit at 1, a rising edge on the hardware trigger starts one; the trigger is first passed through a synchroniser. The all-ones channel code switches the module off. A write to the channel register during a conversion cancels that conversion.

The control is one four-state machine. OFF means disabled and is the state after reset. IDLE means enabled and waiting. LAUNCH is the cycle in which the start pulse is out. BUSY means the conversion is in flight. The transitions are:
- disable-write: any state to OFF, on a channel write of 11111.
- soft-launch: any state to LAUNCH, on a channel write of another code while the trigger bit is 0.
- arm: any state to IDLE, on a channel write of another code while the trigger bit is 1.
- hard-launch: IDLE to LAUNCH, on a trigger edge while the trigger bit is 1.
- issue: LAUNCH to BUSY.
- finish: BUSY to IDLE, on conversion-done.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset, the status/control register reads 0x00 and the channel register reads 0x1F. `mod_en`, `busy`, `conv_start` and `conv_abort` are all 0.
- R2: `rd_sel`/`wr_sel` = 0 addresses the channel register, which reads {3'b000, code}. A value of 1 addresses the status/control register, which reads {busy, trigger bit, compare enable, compare direction, 4'b0000}. Bit 7 and bits 3:0 ignore writes, and bits 6:4 store what was written.
- R3: With the trigger bit at 0, a channel write of any code other than 11111 makes `conv_start` high for exactly one cycle, in the cycle after the write edge. `conv_chan` equals the written code during that cycle.
- R4: `busy` is high from the start-pulse cycle until a `conv_done` is sampled after the start cycle. It is low in the cycle that follows that sample. `conv_done` is not acted on in the start cycle itself.
- R5: With the trigger bit at 1, a rising edge on `hw_trig` gives `conv_start` in the third cycle after the rising input is first sampled. `conv_chan` then equals the stored channel code. A level that stays high gives only one start.
- R6: A rising edge on `hw_trig` that is detected while a conversion is active is dropped. It gives no start, either then or after the conversion ends.
- R7: A channel write while `busy` is high makes `conv_abort` high for one cycle after the write edge. With the trigger bit at 0, a new conversion starts in that same cycle, on the new code, and `busy` stays high. With the trigger bit at 1, `busy` goes low and nothing starts.
- R8: A channel write of 11111 clears `busy` and `mod_en` and holds `conv_start` low. If a conversion was active, it also pulses `conv_abort`. Hardware edges have no effect while the module is off. The next channel write of another code re-enables the module.
- R9: The codes 11100, 11101 and 11110 are ordinary channel codes. They start conversions, and `conv_chan` carries them unchanged.
- R10: With the trigger bit at 0, `hw_trig` never starts a conversion.
- R11: A status/control write neither starts nor ends a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 channel, 1 status/control |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read target: 0 channel, 1 status/control |
| rd_data | output | 8 | Read data (combinational) |
| hw_trig | input | 1 | Asynchronous hardware trigger |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_abort | output | 1 | One-cycle cancel pulse to the converter |
| conv_chan | output | 5 | Channel code latched with the start pulse |
| mod_en | output | 1 | Module enabled (code not 11111) |
| busy | output | 1 | Conversion active |

## Verification
The properties assume that software writes zeros to status bits 1:0. They also assume that `conv_done` is a single-cycle pulse. The bench masks every random status write with 0x70 and drives `conv_done` from a fixed-latency converter model. That model restarts its count on each observed start and drops a pending completion when it sees an abort. Because the model can still raise `conv_done` in an idle cycle after an abort, the machine's rule of ignoring completion outside BUSY is exercised as well. The random writes, trigger toggles and reads are mixed into cycles with directed sequences for each launch, abort and disable path.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_BUSY   = 2'd3
    } trig_state_e;

    // status/control field positions
    localparam int SC_BUSY_BIT  = 7;
    localparam int SC_HWSEL_BIT = 6;
    localparam int SC_CMPEN_BIT = 5;
    localparam int SC_CMPGT_BIT = 4;

endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic trig_rise
);
    logic [STAGES:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= trig_in;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    assign trig_rise = sync_q[STAGES-1] & ~sync_q[STAGES];

    AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_rise |=> !trig_rise); // R5

endmodule

// File: rtl/adc_trig_regs.sv
module adc_trig_regs
    import adc_trig_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CH_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              chan_wr,
    output logic [CH_W-1:0]   chan_wdata,
    output logic [CH_W-1:0]   chan_code,
    output logic              hw_sel
);
    logic            cmp_en_q;
    logic            cmp_gt_q;
    logic            hw_sel_q;
    logic [CH_W-1:0] chan_q;
    logic            sts_wr;
    logic            wr_unused;

    assign chan_wr    = wr_en & ~wr_sel;
    assign sts_wr     = wr_en &  wr_sel;
    assign chan_wdata = wr_data[CH_W-1:0];
    assign wr_unused  = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q   <= '1;
            hw_sel_q <= 1'b0;
            cmp_en_q <= 1'b0;
            cmp_gt_q <= 1'b0;
        end else begin
            if (chan_wr) chan_q <= chan_wdata;
            if (sts_wr) begin
                hw_sel_q <= wr_data[SC_HWSEL_BIT];
                cmp_en_q <= wr_data[SC_CMPEN_BIT];
                cmp_gt_q <= wr_data[SC_CMPGT_BIT];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_sel) begin
            rd_data[SC_BUSY_BIT]  = busy;
            rd_data[SC_HWSEL_BIT] = hw_sel_q;
            rd_data[SC_CMPEN_BIT] = cmp_en_q;
            rd_data[SC_CMPGT_BIT] = cmp_gt_q;
        end else begin
            rd_data[CH_W-1:0] = chan_q;
        end
    end

    assign chan_code = chan_q;
    assign hw_sel    = hw_sel_q;

    AST_STS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr |=> ({hw_sel_q, cmp_en_q, cmp_gt_q} == $past(wr_data[6:4]))); // R2

endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
    import adc_trig_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chan_wr,
    input  logic [CH_W-1:0] chan_wdata,
    input  logic [CH_W-1:0] chan_code,
    input  logic            hw_sel,
    input  logic            trig_rise,
    input  logic            conv_done,
    output logic            start_o,
    output logic            abort_o,
    output logic            busy_o,
    output logic            mod_en_o,
    output logic [CH_W-1:0] chan_o
);
    localparam logic [CH_W-1:0] OFF_CODE = '1;

    trig_state_e state_q, state_d;
    logic        wr_off;
    logic        active_q;

    assign wr_off   = (chan_wdata == OFF_CODE);
    assign active_q = (state_q == ST_LAUNCH) || (state_q == ST_BUSY);

    // next state
    always_comb begin
        state_d = state_q;
        if (chan_wr && wr_off) begin
            state_d = ST_OFF;                       // disable-write
        end else if (chan_wr) begin
            state_d = hw_sel ? ST_IDLE : ST_LAUNCH; // arm / soft-launch
        end else begin
            unique case (state_q)
                ST_OFF:    state_d = ST_OFF;
                ST_IDLE:   if (hw_sel && trig_rise) state_d = ST_LAUNCH; // hard-launch
                ST_LAUNCH: state_d = ST_BUSY;                           // issue
                ST_BUSY:   if (conv_done) state_d = ST_IDLE;            // finish
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o  <= 1'b0;
            abort_o  <= 1'b0;
            busy_o   <= 1'b0;
            mod_en_o <= 1'b0;
            chan_o   <= '0;
        end else begin
            start_o  <= (state_d == ST_LAUNCH);
            abort_o  <= chan_wr && active_q;
            busy_o   <= (state_d == ST_LAUNCH) || (state_d == ST_BUSY);
            mod_en_o <= (state_d != ST_OFF);
            if (state_d == ST_LAUNCH) chan_o <= chan_wr ? chan_wdata : chan_code;
        end
    end

    AST_START_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o); // R4
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (!start_o || $past(chan_wr))); // R3
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && conv_done && !chan_wr) |=> !busy_o); // R4
    AST_ABORT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_wr && busy_o) |=> abort_o); // R7
    AST_DISABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_wr && wr_off) |=> (!busy_o && !mod_en_o && !start_o)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en_o |-> (!start_o && !busy_o)); // R8
    AST_BUSY_DROPS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_rise && state_q == ST_BUSY && !conv_done && !chan_wr) |=> !start_o); // R6
    AST_SOFT_NO_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_sel && !chan_wr) |=> !start_o); // R10

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl #(
    parameter int DATA_W      = 8,
    parameter int CH_W        = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              hw_trig,
    input  logic              conv_done,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [CH_W-1:0]   conv_chan,
    output logic              mod_en,
    output logic              busy
);
    logic            chan_wr;
    logic [CH_W-1:0] chan_wdata;
    logic [CH_W-1:0] chan_code;
    logic            hw_sel;
    logic            trig_rise;

    adc_trig_regs #(.DATA_W(DATA_W), .CH_W(CH_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_sel     (rd_sel),
        .busy       (busy),
        .rd_data    (rd_data),
        .chan_wr    (chan_wr),
        .chan_wdata (chan_wdata),
        .chan_code  (chan_code),
        .hw_sel     (hw_sel)
    );

    adc_trig_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_in   (hw_trig),
        .trig_rise (trig_rise)
    );

    adc_trig_fsm #(.CH_W(CH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_wr    (chan_wr),
        .chan_wdata (chan_wdata),
        .chan_code  (chan_code),
        .hw_sel     (hw_sel),
        .trig_rise  (trig_rise),
        .conv_done  (conv_done),
        .start_o    (conv_start),
        .abort_o    (conv_abort),
        .busy_o     (busy),
        .mod_en_o   (mod_en),
        .chan_o     (conv_chan)
    );

endmodule

// File: tb/adc_trig_ctrl_bench.sv
`timescale 1ns/1ps
module adc_trig_ctrl_bench;
    localparam int LAT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, hw_trig = 1'b0, conv_done = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       conv_start, conv_abort, mod_en, busy;
    logic [4:0] conv_chan;

    int n_chk = 0, n_bad = 0, start_cnt = 0, conv_cnt = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    adc_trig_ctrl u_adc_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .hw_trig(hw_trig), .conv_done(conv_done),
        .conv_start(conv_start), .conv_abort(conv_abort), .conv_chan(conv_chan),
        .mod_en(mod_en), .busy(busy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, advanced at each clock edge from the requirements
    logic       m_off, m_busy, m_start, m_abort, m_sel, m_cen, m_cgt;
    logic [4:0] m_chan, m_chan_o;
    logic       t1, t2, t3;

    function automatic logic [7:0] exp_rd(input logic sel);
        return sel ? {m_busy, m_sel, m_cen, m_cgt, 4'b0000} : {3'b000, m_chan};
    endfunction

    always @(posedge clk) begin
        logic edge_v, cw;
        logic [4:0] code;
        if (!rst_n) begin
            m_off = 1; m_busy = 0; m_start = 0; m_abort = 0;
            m_sel = 0; m_cen = 0; m_cgt = 0; m_chan = 5'h1F; m_chan_o = 5'h00;
            t1 = 0; t2 = 0; t3 = 0;
        end else begin
            edge_v = t2 && !t3;
            t3 = t2; t2 = t1; t1 = hw_trig;
            cw = wr_en && !wr_sel;
            code = wr_data[4:0];
            m_abort = cw && m_busy;
            if (cw) begin
                m_chan = code;
                if (code == 5'h1F) begin m_off = 1; m_busy = 0; m_start = 0; end
                else if (!m_sel) begin m_off = 0; m_busy = 1; m_start = 1; m_chan_o = code; end
                else begin m_off = 0; m_busy = 0; m_start = 0; end
            end else if (m_off) begin
                m_start = 0;
            end else if (m_start) begin
                m_start = 0;
            end else if (m_busy) begin
                if (conv_done) m_busy = 0;
            end else if (m_sel && edge_v) begin
                m_start = 1; m_busy = 1; m_chan_o = m_chan;
            end
            if (wr_en && wr_sel) {m_sel, m_cen, m_cgt} = wr_data[6:4];
        end
    end

    // converter model with fixed latency, plus scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            conv_cnt = 0; conv_done = 0;
        end else begin
            chk("R3 start", {7'b0, conv_start}, {7'b0, m_start});
            chk("R4 busy", {7'b0, busy}, {7'b0, m_busy});
            chk("R7 abort", {7'b0, conv_abort}, {7'b0, m_abort});
            chk("R8 mod_en", {7'b0, mod_en}, {7'b0, !m_off});
            chk("R9 chan", {3'b0, conv_chan}, {3'b0, m_chan_o});
            chk("R2 rd_data", rd_data, exp_rd(rd_sel));
            if (conv_start) start_cnt++;
            conv_done = 0;
            if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0) conv_done = 1;
            end
            if (conv_abort) conv_cnt = 0;
            if (conv_start) conv_cnt = LAT;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && busy; i++) step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        int n, c;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        // R1 reset state
        rd_sel = 1; #1; chk("R1 status reset", rd_data, 8'h00);
        rd_sel = 0; #1; chk("R1 chan reset", rd_data, 8'h1F);
        chk("R1 outputs", {4'b0, mod_en, busy, conv_start, conv_abort}, 8'h00);
        // R2 reserved bits ignore writes
        wr(1, 8'h3C);
        rd_sel = 1; #1; chk("R2 status readback", rd_data, 8'h30);
        wr(1, 8'h00);
        // R3 + R4 software launch and busy window
        wr(0, 8'h05);
        chk("R3 start", {7'b0, conv_start}, 8'h01);
        chk("R3 chan", {3'b0, conv_chan}, 8'h05);
        n = 0;
        while (busy && n < 50) begin
            n++; step();
            if (n == 1) chk("R3 single pulse", {7'b0, conv_start}, 8'h00);
        end
        chk("R4 busy cycles", n[7:0], 8'(LAT + 1));
        // R9 special codes
        for (int k = 28; k <= 30; k++) begin
            wr(0, 8'(k));
            chk("R9 start", {7'b0, conv_start}, 8'h01);
            chk("R9 code", {3'b0, conv_chan}, 8'(k));
            wait_idle();
        end
        // R11 status writes do not start or stop
        wr(0, 8'h03); step();
        wr(1, 8'h00);
        chk("R11 busy kept", {7'b0, busy}, 8'h01);
        wait_idle();
        c = start_cnt;
        wr(1, 8'h00); repeat (4) step();
        chk("R11 no start", 8'(start_cnt - c), 8'h00);
        // R10 hardware trigger ignored in software mode
        c = start_cnt;
        for (int k = 0; k < 6; k++) begin hw_trig = ~hw_trig; repeat (3) step(); end
        hw_trig = 0; repeat (4) step();
        chk("R10 no hw start", 8'(start_cnt - c), 8'h00);
        // R5 hardware launch latency and single start
        wr(1, 8'h40);
        wr(0, 8'h06);
        chk("R5 arm no start", {6'b0, conv_start, busy}, 8'h00);
        c = start_cnt;
        hw_trig = 1; step(); step();
        chk("R5 not yet", {7'b0, conv_start}, 8'h00);
        step();
        chk("R5 start", {7'b0, conv_start}, 8'h01);
        chk("R5 chan", {3'b0, conv_chan}, 8'h06);
        wait_idle(); repeat (6) step();
        chk("R5 one start", 8'(start_cnt - c), 8'h01);
        // R6 edge during conversion dropped
        hw_trig = 0; repeat (4) step();
        c = start_cnt;
        hw_trig = 1; repeat (3) step();
        hw_trig = 0; step(); hw_trig = 1;
        wait_idle(); repeat (8) step();
        chk("R6 dropped edge", 8'(start_cnt - c), 8'h01);
        // R7 abort in hardware mode
        hw_trig = 0; repeat (4) step();
        hw_trig = 1; repeat (3) step();
        wr(0, 8'h07);
        chk("R7 hw abort", {5'b0, conv_abort, busy, conv_start}, 8'h04);
        hw_trig = 0;
        // R7 abort and restart in software mode
        wr(1, 8'h00);
        wr(0, 8'h08); step();
        wr(0, 8'h09);
        chk("R7 sw restart", {5'b0, conv_abort, busy, conv_start}, 8'h07);
        chk("R7 new code", {3'b0, conv_chan}, 8'h09);
        wait_idle();
        // R8 disable code
        wr(0, 8'h0A);
        wr(0, 8'h1F);
        chk("R8 disable", {4'b0, conv_abort, mod_en, busy, conv_start}, 8'h08);
        c = start_cnt;
        wr(1, 8'h40);
        for (int k = 0; k < 4; k++) begin hw_trig = ~hw_trig; repeat (4) step(); end
        chk("R8 hw ignored off", 8'(start_cnt - c), 8'h00);
        wr(1, 8'h00);
        wr(0, 8'h1F);
        chk("R8 no start off", {6'b0, conv_start, mod_en}, 8'h00);
        wr(0, 8'h02);
        chk("R8 reenable", {6'b0, conv_start, mod_en}, 8'h03);
        wait_idle();
        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            wr_en = ($urandom % 4) == 0;
            wr_sel = ($urandom % 3) == 0;
            if (wr_sel) wr_data = 8'($urandom) & 8'h70;
            else wr_data = (($urandom % 6) == 0) ? 8'h1F : 8'($urandom % 31);
            if (($urandom % 5) == 0) hw_trig = ~hw_trig;
            rd_sel = $urandom % 2;
            step();
        end
        wr_en = 0; repeat (10) step();
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

endmodule